// File: doc/BRIEF.md
# Prioritized Next-PC Selector

The block picks the fetch address that an in-order pipeline uses in the following cycle. It holds the program counter in a register. Each cycle it takes the highest-priority request from seven possible sources and loads the address that request carries. When nothing redirects fetch, the address simply advances by one instruction. The register output drives the instruction fetch directly.

A branch resolved in execute is treated as mispredicted when its computed target differs from the PC of the instruction that follows it down the pipe. The selector performs that comparison itself. Trap entry, trap return and replay requests from the memory or execute stage take precedence over branch events. The block also raises a flush pulse, one cycle long and aligned with the new PC, whenever fetch is redirected away from the predicted path. A stall input freezes the PC, but it cannot hold back the urgent redirects.

Top module: `next_pc_sel`

## Requirements
- R1: While rst_ni is low, pc_o equals RESET_PC, flush_o is 0 and src_o is 7 (hold).
- R2: With no request active and no stall, pc_o advances by 4 modulo 2^PC_W on each clock edge, with src_o = 0.
- R3: A predicted-taken request (pred_taken_i) with no higher request loads pred_target_i, with src_o = 1 and no flush.
- R4: A resolved branch (res_vld_i) whose res_target_i differs from next_inst_pc_i is a mispredict and loads res_target_i, with src_o = 2.
- R5: A resolved branch whose target equals next_inst_pc_i causes no redirect, and the lower-priority choice applies.
- R6: An execute-stage replay loads rpl_x_pc_i, with src_o = 3.
- R7: A memory-stage replay wins over an execute-stage replay, and any replay wins over mispredict and prediction; a memory replay loads rpl_m_pc_i, with src_o = 4.
- R8: A trap wins over every other request and loads trap_base_i, with src_o = 6.
- R9: A trap return with no trap loads epc_i, with src_o = 5.
- R10: stall_i holds pc_o unchanged and sets src_o = 7, unless a trap, trap return or replay is present; those still redirect.
- R11: flush_o is 1 for exactly the cycle after a redirect of type 2..6, and 0 after sequential, predicted or held cycles.
- R12: src_o reports the source that produced the current pc_o, updated together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Fetch stall |
| pred_taken_i | input | 1 | Predictor says taken |
| pred_target_i | input | PC_W | Predicted target |
| res_vld_i | input | 1 | Branch resolved in execute |
| res_target_i | input | PC_W | Computed correct target |
| next_inst_pc_i | input | PC_W | PC of the instruction following the branch |
| rpl_x_i | input | 1 | Replay from execute |
| rpl_x_pc_i | input | PC_W | Execute replay PC |
| rpl_m_i | input | 1 | Replay from memory |
| rpl_m_pc_i | input | PC_W | Memory replay PC |
| trap_i | input | 1 | Trap or interrupt taken |
| trap_base_i | input | PC_W | Handler address |
| trap_ret_i | input | 1 | Return from handler |
| epc_i | input | PC_W | Saved restore PC |
| pc_o | output | PC_W | Fetch PC |
| flush_o | output | 1 | Flush fetch and decode |
| src_o | output | 3 | Source of current pc_o |

## Verification
Properties check on every cycle that a trap always loads the handler address with a flush, that a trap return loads the saved PC, and that a stall with no urgent request freezes the PC. They also check that flush appears only with a redirect source code and that the idle path advances by 4. Only the bench scenarios can show the full priority order under colliding requests. The same holds for the matching-target case where a resolved branch must not redirect, and for a mispredict that a stall swallows. A behavioural model compares every output on every clock through directed and random traffic.

// File: rtl/nps_pkg.sv
package nps_pkg;
  typedef enum logic [2:0] {
    SRC_SEQ  = 3'd0,
    SRC_PRED = 3'd1,
    SRC_MISP = 3'd2,
    SRC_RPX  = 3'd3,
    SRC_RPM  = 3'd4,
    SRC_RET  = 3'd5,
    SRC_TRAP = 3'd6,
    SRC_HOLD = 3'd7
  } nps_src_e;

  function automatic logic is_redirect(nps_src_e s);
    return (s != SRC_SEQ) && (s != SRC_PRED) && (s != SRC_HOLD);
  endfunction
endpackage

// File: rtl/nps_misp_detect.sv
module nps_misp_detect #(
  parameter int PC_W = 32
) (
  input  logic            res_vld_i,
  input  logic [PC_W-1:0] res_target_i,
  input  logic [PC_W-1:0] next_inst_pc_i,
  output logic            misp_o
);
  assign misp_o = res_vld_i && (res_target_i != next_inst_pc_i);
endmodule

// File: rtl/nps_prio.sv
module nps_prio
  import nps_pkg::*;
(
  input  logic     trap_i,
  input  logic     ret_i,
  input  logic     rpl_m_i,
  input  logic     rpl_x_i,
  input  logic     misp_i,
  input  logic     pred_i,
  input  logic     stall_i,
  output nps_src_e src_o
);
  always_comb begin
    if (trap_i)       src_o = SRC_TRAP;
    else if (ret_i)   src_o = SRC_RET;
    else if (rpl_m_i) src_o = SRC_RPM;
    else if (rpl_x_i) src_o = SRC_RPX;
    else if (stall_i) src_o = SRC_HOLD;   // stall only masks branch-level sources
    else if (misp_i)  src_o = SRC_MISP;
    else if (pred_i)  src_o = SRC_PRED;
    else              src_o = SRC_SEQ;
  end
endmodule

// File: rtl/nps_pc_reg.sv
module nps_pc_reg
  import nps_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter int              INST_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC   = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  nps_src_e        sel_i,
  input  logic [PC_W-1:0] pred_pc_i,
  input  logic [PC_W-1:0] fix_pc_i,
  input  logic [PC_W-1:0] rpx_pc_i,
  input  logic [PC_W-1:0] rpm_pc_i,
  input  logic [PC_W-1:0] ret_pc_i,
  input  logic [PC_W-1:0] trap_pc_i,
  output logic [PC_W-1:0] pc_o,
  output logic            flush_o,
  output nps_src_e        src_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

  logic [PC_W-1:0] pc_d;

  always_comb begin
    unique case (sel_i)
      SRC_SEQ:  pc_d = pc_o + STEP;
      SRC_PRED: pc_d = pred_pc_i;
      SRC_MISP: pc_d = fix_pc_i;
      SRC_RPX:  pc_d = rpx_pc_i;
      SRC_RPM:  pc_d = rpm_pc_i;
      SRC_RET:  pc_d = ret_pc_i;
      SRC_TRAP: pc_d = trap_pc_i;
      default:  pc_d = pc_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o    <= RESET_PC;
      flush_o <= 1'b0;
      src_o   <= SRC_HOLD;
    end else begin
      pc_o    <= pc_d;
      flush_o <= is_redirect(sel_i);
      src_o   <= sel_i;
    end
  end
endmodule

// File: rtl/next_pc_sel.sv
module next_pc_sel
  import nps_pkg::*;
#(
  parameter int              PC_W       = 32,
  parameter int              INST_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC   = 32'h0000_1000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stall_i,
  input  logic            pred_taken_i,
  input  logic [PC_W-1:0] pred_target_i,
  input  logic            res_vld_i,
  input  logic [PC_W-1:0] res_target_i,
  input  logic [PC_W-1:0] next_inst_pc_i,
  input  logic            rpl_x_i,
  input  logic [PC_W-1:0] rpl_x_pc_i,
  input  logic            rpl_m_i,
  input  logic [PC_W-1:0] rpl_m_pc_i,
  input  logic            trap_i,
  input  logic [PC_W-1:0] trap_base_i,
  input  logic            trap_ret_i,
  input  logic [PC_W-1:0] epc_i,
  output logic [PC_W-1:0] pc_o,
  output logic            flush_o,
  output logic [2:0]      src_o
);
  logic     misp;
  nps_src_e sel;
  nps_src_e src_q;

  nps_misp_detect #(.PC_W(PC_W)) u_misp (
    .res_vld_i      (res_vld_i),
    .res_target_i   (res_target_i),
    .next_inst_pc_i (next_inst_pc_i),
    .misp_o         (misp)
  );

  nps_prio u_prio (
    .trap_i  (trap_i),
    .ret_i   (trap_ret_i),
    .rpl_m_i (rpl_m_i),
    .rpl_x_i (rpl_x_i),
    .misp_i  (misp),
    .pred_i  (pred_taken_i),
    .stall_i (stall_i),
    .src_o   (sel)
  );

  nps_pc_reg #(.PC_W(PC_W), .INST_BYTES(INST_BYTES), .RESET_PC(RESET_PC)) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .pred_pc_i (pred_target_i),
    .fix_pc_i  (res_target_i),
    .rpx_pc_i  (rpl_x_pc_i),
    .rpm_pc_i  (rpl_m_pc_i),
    .ret_pc_i  (epc_i),
    .trap_pc_i (trap_base_i),
    .pc_o      (pc_o),
    .flush_o   (flush_o),
    .src_o     (src_q)
  );

  assign src_o = src_q;
endmodule

// File: rtl/nps_chk.sv
module nps_chk #(
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            stall_i,
  input logic            pred_taken_i,
  input logic            res_vld_i,
  input logic            rpl_x_i,
  input logic            rpl_m_i,
  input logic            trap_i,
  input logic [PC_W-1:0] trap_base_i,
  input logic            trap_ret_i,
  input logic [PC_W-1:0] epc_i,
  input logic [PC_W-1:0] pc_o,
  input logic            flush_o,
  input logic [2:0]      src_o
);
  logic urgent;
  assign urgent = trap_i || trap_ret_i || rpl_m_i || rpl_x_i;

  // R8
  trap_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_i |=> (pc_o == $past(trap_base_i)) && flush_o);

  // R9
  trap_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_ret_i && !trap_i) |=> (pc_o == $past(epc_i)) && flush_o);

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !urgent) |=> $stable(pc_o) && !flush_o);

  // R11
  flush_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (src_o >= 3'd2) && (src_o <= 3'd6));

  // R2
  seq_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !urgent && !res_vld_i && !pred_taken_i)
      |=> pc_o == $past(pc_o) + PC_W'(INST_BYTES));
endmodule

bind next_pc_sel nps_chk #(.PC_W(PC_W), .INST_BYTES(INST_BYTES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stall_i      (stall_i),
  .pred_taken_i (pred_taken_i),
  .res_vld_i    (res_vld_i),
  .rpl_x_i      (rpl_x_i),
  .rpl_m_i      (rpl_m_i),
  .trap_i       (trap_i),
  .trap_base_i  (trap_base_i),
  .trap_ret_i   (trap_ret_i),
  .epc_i        (epc_i),
  .pc_o         (pc_o),
  .flush_o      (flush_o),
  .src_o        (src_o)
);

// File: tb/sim_next_pc_sel.sv
module sim_next_pc_sel;
  localparam int          W     = 32;
  localparam logic [31:0] RPC   = 32'h0000_1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic stall = 0, pred = 0, rvld = 0, rx = 0, rm = 0, trap = 0, tret = 0;
  logic [W-1:0] ptgt = 0, rtgt = 0, npc = 0, rxpc = 0, rmpc = 0, tbase = 0, epc = 0;
  logic [W-1:0] pc;
  logic         flush;
  logic [2:0]   src;

  int checks = 0, errors = 0;
  logic [W-1:0] m_pc;
  logic         m_flush;
  int           m_src;
  bit           done = 0;

  always #2 clk = ~clk;

  next_pc_sel u0 (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall),
    .pred_taken_i(pred), .pred_target_i(ptgt),
    .res_vld_i(rvld), .res_target_i(rtgt), .next_inst_pc_i(npc),
    .rpl_x_i(rx), .rpl_x_pc_i(rxpc), .rpl_m_i(rm), .rpl_m_pc_i(rmpc),
    .trap_i(trap), .trap_base_i(tbase), .trap_ret_i(tret), .epc_i(epc),
    .pc_o(pc), .flush_o(flush), .src_o(src)
  );

  task automatic compare(input string tag);
    checks++;
    if (pc !== m_pc || flush !== m_flush || int'(src) != m_src) begin
      errors++;
      $display("FAIL %s: pc=%h flush=%0b src=%0d expected pc=%h flush=%0b src=%0d",
               tag, pc, flush, src, m_pc, m_flush, m_src);
    end
  endtask

  // behavioural reference: evaluate sampled inputs, choose by priority
  task automatic model_update();
    int s;
    logic [W-1:0] n;
    if (trap)                            begin s = 6; n = tbase; end
    else if (tret)                       begin s = 5; n = epc;   end
    else if (rm)                         begin s = 4; n = rmpc;  end
    else if (rx)                         begin s = 3; n = rxpc;  end
    else if (stall)                      begin s = 7; n = m_pc;  end
    else if (rvld && (rtgt != npc))      begin s = 2; n = rtgt;  end
    else if (pred)                       begin s = 1; n = ptgt;  end
    else                                 begin s = 0; n = m_pc + 32'd4; end
    m_pc = n; m_src = s; m_flush = (s >= 2 && s <= 6);
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle();
    stall = 0; pred = 0; rvld = 0; rx = 0; rm = 0; trap = 0; tret = 0;
  endtask

  initial begin
    m_pc = RPC; m_flush = 0; m_src = 7;
    #9;
    compare("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step("R2 sequential");

    pred = 1; ptgt = 32'h0000_2000; step("R3 predicted");
    idle(); step("R11 no flush after predict");

    rvld = 1; rtgt = 32'h0000_3000; npc = 32'h0000_2008; pred = 1; ptgt = 32'h5;
    step("R4 mispredict");
    rtgt = 32'h0000_4000; npc = 32'h0000_4000; step("R5 match no redirect");
    idle(); step("R11 flush drops");

    rx = 1; rxpc = 32'h0000_5000; rvld = 1; rtgt = 32'h1; npc = 32'h2;
    step("R6 replay execute");
    rm = 1; rmpc = 32'h0000_6000; step("R7 memory replay over execute");
    idle();

    trap = 1; tbase = 32'h0000_0100; tret = 1; epc = 32'h0000_7000; rm = 1; rx = 1;
    stall = 1; step("R8 trap beats all");
    trap = 0; step("R9 trap return");
    idle();

    stall = 1; pred = 1; ptgt = 32'hDEAD_0000; step("R10 stall holds");
    rvld = 1; rtgt = 32'h9; npc = 32'hA; step("R10 stall swallows mispredict");
    rx = 1; rxpc = 32'h0000_8000; step("R10 replay passes stall");
    idle();

    rx = 1; rxpc = 32'hFFFF_FFF8; step("R12 load near top");
    idle(); step("R2 step");
    step("R2 wraparound");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      trap  = (r[3:0] == 0);
      tret  = (r[7:4] == 0);
      rm    = (r[11:8] == 0);
      rx    = (r[15:12] < 2);
      stall = (r[19:16] < 3);
      pred  = r[20];
      rvld  = (r[23:21] < 3);
      npc   = {24'h0, r[31:24]};
      rtgt  = r[24] ? npc : {24'h1, r[31:24]};
      ptgt = $urandom; rxpc = $urandom; rmpc = $urandom;
      tbase = $urandom; epc = $urandom;
      step("R12 random mix");
    end
    idle();

    @(negedge clk); rst_n = 1'b0;
    m_pc = RPC; m_flush = 0; m_src = 7;
    #1 compare("R1 reset again");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule